// File: doc/BRIEF.md
# Serial Converter Output Port Model

This block is a synthesizable device-side stand-in for the digital serial port of a 10-bit sampling converter. A host controller under test drives an active-low select and a serial shift clock; the block answers on a serial data pin with an output enable, as a tri-state pad would. The analog conversion is replaced by latching a word from a test source, so a bench knows exactly which value the host should read back.

Both host inputs are brought into the system clock domain through a synchronizer chain. A select change counts only after its new level has held for a set number of system cycles. Each transfer shifts out the stored result, most significant bit first. The falling shift-clock edge that completes the word opens a conversion window, and the new result is latched when that window closes. When select stays low, the window's end also starts the next transfer.

Two host timing errors are flagged. The first is an 11th rising shift edge that arrives too late after the word has completed. This loses synchronization, and only a fresh select falling edge recovers from it. The second is a shift clock that goes past the longest allowed transfer. All delays are parameters in system cycles.

Top module: `serial_adc_port_model`

## Requirements
- R1: `sdo_oe` is 1 exactly while the accepted select level is low. It rises on the cycle after a select falling edge is accepted. While it is 0, `sdo` is 0.
- R2: A select change is accepted only after the synchronized level has differed from the accepted level for CS_HOLD_CYC consecutive cycles. A shorter pulse leaves `sdo_oe` unchanged.
- R3: When a transfer starts, `sdo` shows bit WORD_W-1 of the stored result. Each counted falling shift edge moves to the next lower bit. After WORD_W falling edges, `sdo` stays 0 for the rest of the transfer.
- R4: Shift-clock edges are ignored while the accepted select level is high. Clocking with select high never opens a conversion window.
- R5: The WORD_W-th counted falling edge raises `conv_busy` for CONV_CYC cycles.
- R6: When the window closes, `sample` is latched as the stored result. That value is the word shifted out in the next transfer.
- R7: If select is low when the window closes, the new result is loaded at once, so `sdo` shows its top bit. The clock count also restarts.
- R8: A rising shift edge with the count at WORD_W that comes LATE_CYC or more cycles after the window opened sets `sync_lost`. While it is set, shift-clock edges and the window-end reload are ignored. The next accepted select falling edge clears it.
- R9: A falling shift edge after MAX_CLKS counted edges sets `clk_overrun` and does not shift. The next accepted select falling edge clears it.
- R10: After reset, `sdo_oe`, `sdo`, `conv_busy`, `sync_lost` and `clk_overrun` are 0, and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host select, active low, asynchronous |
| io_clk | input | 1 | Host shift clock, asynchronous |
| sample | input | WORD_W | Word latched as the next result when a window closes |
| sdo | output | 1 | Serial data, MSB first |
| sdo_oe | output | 1 | Output enable for the data pad |
| conv_busy | output | 1 | Conversion window in progress |
| sync_lost | output | 1 | Late 11th clock seen; held until select is re-asserted |
| clk_overrun | output | 1 | More than MAX_CLKS falling edges in one transfer |

## Verification
A cycle-level reference model in the bench runs alongside the design and is compared on every clock. The directed patterns each separate one behaviour from another:
- Select toggled between 10-clock transfers shows that the result is latched at the window's end and not at transfer start.
- Select held low shows the reload at the window's end.
- A 16-clock transfer exposes the zero tail.
- A short select pulse and clocking with select high show that both are ignored.
- A stalled 11th clock, against a prompt one, separates the lost-sync path from a normal long transfer.
- A 17-clock transfer trips the overrun flag.

// File: rtl/sadc_pkg.sv
package sadc_pkg;
   typedef struct packed {
      logic rise;
      logic fall;
   } clk_edge_t;
endpackage

// File: rtl/sadc_sync.sv
module sadc_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= RST_VAL;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL}};
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sadc_cs_filter.sv
module sadc_cs_filter #(
   parameter int HOLD_CYC = 143
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_in,
   output logic lvl_q,
   output logic acc_fall
);
   localparam int            HW    = $clog2(HOLD_CYC + 1);
   localparam logic [HW-1:0] HLAST = HW'(HOLD_CYC - 1);

   logic [HW-1:0] hold_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q    <= 1'b1;
         hold_cnt <= '0;
      end else if (lvl_in != lvl_q) begin
         if (hold_cnt == HLAST) begin
            lvl_q    <= lvl_in;
            hold_cnt <= '0;
         end else begin
            hold_cnt <= hold_cnt + 1'b1;
         end
      end else begin
         hold_cnt <= '0;
      end
   end

   assign acc_fall = ~lvl_in & lvl_q & (hold_cnt == HLAST);

   // R2: the accepted level only moves after a full hold interval
   assert_hold_time_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(lvl_q) |-> $past(hold_cnt) == HLAST);
endmodule

// File: rtl/sadc_conv_timer.sv
module sadc_conv_timer #(
   parameter int CONV_CYC = 2100,
   parameter int LATE_CYC = 950
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy,
   output logic done,
   output logic late
);
   localparam int            EW    = $clog2(CONV_CYC + 1);
   localparam logic [EW-1:0] ELAST = EW'(CONV_CYC - 1);
   localparam logic [EW-1:0] ELATE = EW'(LATE_CYC);

   logic [EW-1:0] elapsed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         elapsed <= '0;
      end else if (start) begin
         busy    <= 1'b1;
         elapsed <= '0;
      end else if (done) begin
         busy    <= 1'b0;
      end else if (busy) begin
         elapsed <= elapsed + 1'b1;
      end
   end

   assign done = busy & (elapsed == ELAST);
   assign late = busy & (elapsed >= ELATE);

   // R5: a window never outlives its length
   assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> elapsed <= ELAST);
endmodule

// File: rtl/serial_adc_port_model.sv
module serial_adc_port_model #(
   parameter int WORD_W      = 10,
   parameter int MAX_CLKS    = 16,
   parameter int SYNC_STAGES = 2,
   parameter int CS_HOLD_CYC = 143,
   parameter int CONV_CYC    = 2100,
   parameter int LATE_CYC    = 950
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              io_clk,
   input  logic [WORD_W-1:0] sample,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              conv_busy,
   output logic              sync_lost,
   output logic              clk_overrun
);
   import sadc_pkg::*;

   localparam int               CNT_W    = $clog2(MAX_CLKS + 1);
   localparam logic [CNT_W-1:0] CNT_WORD = CNT_W'(WORD_W);
   localparam logic [CNT_W-1:0] CNT_PRE  = CNT_W'(WORD_W - 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(MAX_CLKS);

   initial begin
      assert (WORD_W >= 2) else $error("WORD_W must be at least 2");
      assert (MAX_CLKS >= WORD_W) else $error("MAX_CLKS below WORD_W");
      assert (SYNC_STAGES >= 1) else $error("SYNC_STAGES must be at least 1");
      assert (CS_HOLD_CYC >= 1) else $error("CS_HOLD_CYC must be at least 1");
      assert (LATE_CYC < CONV_CYC) else $error("LATE_CYC must be below CONV_CYC");
   end

   logic cs_s, io_s, io_prev, cs_q, cs_acc_fall;
   logic win_start, conv_done, conv_late, active;
   logic [CNT_W-1:0]  cnt;
   logic [WORD_W-1:0] shreg, result;
   clk_edge_t         ev;

   sadc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync_cs (
      .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));

   sadc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sync_io (
      .clk(clk), .rst_n(rst_n), .d(io_clk), .q(io_s));

   sadc_cs_filter #(.HOLD_CYC(CS_HOLD_CYC)) i_cs_filter (
      .clk(clk), .rst_n(rst_n), .lvl_in(cs_s), .lvl_q(cs_q), .acc_fall(cs_acc_fall));

   sadc_conv_timer #(.CONV_CYC(CONV_CYC), .LATE_CYC(LATE_CYC)) i_timer (
      .clk(clk), .rst_n(rst_n), .start(win_start),
      .busy(conv_busy), .done(conv_done), .late(conv_late));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) io_prev <= 1'b0;
      else        io_prev <= io_s;
   end

   assign active    = ~cs_q & ~sync_lost;
   assign ev        = '{rise: io_s & ~io_prev & active, fall: ~io_s & io_prev & active};
   assign win_start = ev.fall & (cnt == CNT_PRE);

   // later statements take priority: window end, then clock, then select
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg       <= '0;
         result      <= '0;
         cnt         <= '0;
         sync_lost   <= 1'b0;
         clk_overrun <= 1'b0;
      end else begin
         if (conv_done) begin
            result <= sample;
            if (active) begin
               shreg <= sample;
               cnt   <= '0;
            end
         end
         if (ev.fall) begin
            if (cnt == CNT_MAX) begin
               clk_overrun <= 1'b1;
            end else begin
               cnt   <= cnt + 1'b1;
               shreg <= {shreg[WORD_W-2:0], 1'b0};
            end
         end
         if (ev.rise && cnt == CNT_WORD && conv_late) sync_lost <= 1'b1;
         if (cs_acc_fall) begin
            shreg       <= result;
            cnt         <= '0;
            sync_lost   <= 1'b0;
            clk_overrun <= 1'b0;
         end
      end
   end

   assign sdo_oe = ~cs_q;
   assign sdo    = sdo_oe & shreg[WORD_W-1];

   // R1: the driver turns on only after an accepted select fall
   assert_oe_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdo_oe) |-> $past(cs_acc_fall));
   // R3: once the word is out, only zeros remain
   assert_zero_tail_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt >= CNT_WORD |-> shreg == '0);
   // R4: an idle select freezes the clock count
   assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_q && !conv_done && !cs_acc_fall) |=> $stable(cnt));
   // R5: the window opens on the word-completing edge
   assert_window_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_busy) |-> cnt == CNT_WORD);
   // R8: loss of sync only from a rise after a complete word inside a window
   assert_lost_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sync_lost) |-> ($past(cnt) == CNT_WORD && $past(conv_busy)));
   // R9: overrun only at the clock limit
   assert_overrun_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_overrun) |-> cnt == CNT_MAX);
endmodule

// File: tb/test_serial_adc_port_model.sv
module test_serial_adc_port_model;
   localparam int W     = 10;
   localparam int MAXC  = 16;
   localparam int HOLD  = 3;
   localparam int CONV  = 80;
   localparam int LATE  = 20;

   logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, io_clk = 1'b0;
   logic [W-1:0] sample = '0;
   logic sdo, sdo_oe, conv_busy, sync_lost, clk_overrun;
   int total = 0, bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   serial_adc_port_model #(.WORD_W(W), .MAX_CLKS(MAXC), .SYNC_STAGES(2),
      .CS_HOLD_CYC(HOLD), .CONV_CYC(CONV), .LATE_CYC(LATE)) i_serial_adc_port_model (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk), .sample(sample),
      .sdo(sdo), .sdo_oe(sdo_oe), .conv_busy(conv_busy),
      .sync_lost(sync_lost), .clk_overrun(clk_overrun));

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
      end
   endtask

   // behavioural reference, one step per clock
   int m_cs0, m_cs1, m_io0, m_io1, m_iop, m_csq, m_hc, m_cnt, m_el, c0;
   bit m_busy, m_lost, m_ovr, act, fe, re, accf, dn, lt;
   logic [W-1:0] m_sh, m_res, s0, r0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cs0 = 1; m_cs1 = 1; m_io0 = 0; m_io1 = 0; m_iop = 0; m_csq = 1; m_hc = 0;
         m_cnt = 0; m_el = 0; m_busy = 0; m_lost = 0; m_ovr = 0; m_sh = '0; m_res = '0;
      end else begin
         act  = (m_csq == 0) && !m_lost;
         fe   = (m_iop == 1) && (m_io1 == 0) && act;
         re   = (m_iop == 0) && (m_io1 == 1) && act;
         accf = (m_cs1 == 0) && (m_csq == 1) && (m_hc == HOLD - 1);
         dn   = m_busy && (m_el == CONV - 1);
         lt   = m_busy && (m_el >= LATE);
         c0 = m_cnt; s0 = m_sh; r0 = m_res;
         if (fe && c0 == W - 1) begin m_busy = 1; m_el = 0; end
         else if (dn) m_busy = 0;
         else if (m_busy) m_el++;
         if (dn) begin m_res = sample; if (act) begin m_sh = sample; m_cnt = 0; end end
         if (fe) begin
            if (c0 == MAXC) m_ovr = 1;
            else begin m_cnt = c0 + 1; m_sh = s0 << 1; end
         end
         if (re && c0 == W && lt) m_lost = 1;
         if (accf) begin m_sh = r0; m_cnt = 0; m_lost = 0; m_ovr = 0; end
         if (m_cs1 != m_csq) begin
            if (m_hc == HOLD - 1) begin m_csq = m_cs1; m_hc = 0; end else m_hc++;
         end else m_hc = 0;
         m_iop = m_io1; m_io1 = m_io0; m_io0 = io_clk; m_cs1 = m_cs0; m_cs0 = cs_n;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         check("R1 oe", sdo_oe, (m_csq == 0));
         check("R3 sdo", sdo, (m_csq == 0) && m_sh[W-1]);
         check("R5 busy", conv_busy, m_busy);
         check("R8 lost", sync_lost, m_lost);
         check("R9 overrun", clk_overrun, m_ovr);
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask
   task automatic sel(input logic v);
      cs_n = v; wait_cyc(8);
   endtask
   task automatic xfer(input int n, input int stall, output logic [W-1:0] word, output int tail);
      word = '0; tail = 0;
      for (int i = 0; i < n; i++) begin
         if (i == W) wait_cyc(stall);
         if (i < W) word = {word[W-2:0], sdo}; else tail += int'(sdo);
         io_clk = 1'b1; wait_cyc(2);
         io_clk = 1'b0; wait_cyc(4);
      end
   endtask

   initial begin
      logic [W-1:0] w;
      int t;
      wait_cyc(5); rst_n = 1'b1; wait_cyc(1);
      check("R10 oe", sdo_oe, 0); check("R10 sdo", sdo, 0);
      check("R10 busy", conv_busy, 0); check("R10 lost", sync_lost, 0);
      check("R10 overrun", clk_overrun, 0);

      sample = 10'h2A5;
      sel(1'b0); xfer(10, 0, w, t);
      check("R10 first word zero", w, 0);
      check("R5 window open", conv_busy, 1);
      sel(1'b1); wait_cyc(CONV + 10);
      check("R5 window closed", conv_busy, 0);
      sample = 10'h3FF;
      sel(1'b0); xfer(10, 0, w, t);
      check("R6 latched word", w, 10'h2A5);

      wait_cyc(CONV + 10);
      check("R7 msb after reload", sdo, 1);
      xfer(10, 0, w, t);
      check("R7 continuous word", w, 10'h3FF);
      sample = 10'h0C3;
      wait_cyc(CONV + 10);
      xfer(16, 0, w, t);
      check("R3 long word", w, 10'h0C3);
      check("R3 zero tail", t, 0);
      wait_cyc(CONV + 10);
      sel(1'b1);

      cs_n = 1'b0; wait_cyc(2); cs_n = 1'b1; wait_cyc(10);
      check("R2 short pulse ignored", sdo_oe, 0);

      xfer(12, 0, w, t);
      wait_cyc(4);
      check("R4 no window while idle", conv_busy, 0);

      sample = 10'h3C0;
      sel(1'b0); xfer(12, 30, w, t);
      check("R8 lost set", sync_lost, 1);
      wait_cyc(CONV + 10);
      check("R8 reload ignored", sdo, 0);
      sel(1'b1); sel(1'b0);
      check("R8 lost cleared", sync_lost, 0);
      check("R8 new msb after toggle", sdo, 1);

      wait_cyc(CONV + 10);
      xfer(17, 0, w, t);
      check("R9 overrun set", clk_overrun, 1);
      check("R9 word", w, 10'h3C0);
      sel(1'b1);
      check("R9 overrun held", clk_overrun, 1);
      sel(1'b0);
      check("R9 overrun cleared", clk_overrun, 0);
      wait_cyc(CONV + 10);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule